// File: doc/BRIEF.md
# Store Buffer with High-Water Port Arbitration

This block sits between the commit point of a processor pipeline and the single request port of the second-level cache. Committed stores are queued in order, each with an address, a data word and a byte-enable mask. Atomic, flush and fence operations travel through the same queue. Load misses from the first-level cache share the same port. Every cycle the block decides whether the port carries the oldest queued entry or the pending load miss.

Loads normally have the right of way, because a waiting load stalls the pipeline and a queued store does not. Once the queue has filled to a high-water mark (five entries by default, out of eight), the oldest entry takes priority over loads. This keeps the queue from reaching the point where commit stalls. A fence never uses the port: when it reaches the head, it is removed in that same cycle.

An entry presented in a cycle is written at the next clock edge and can be granted in the cycle after that. This lets a store enter in the same cycle as the operation that produces its data. When all slots are taken, the block raises a stall and refuses new entries until one drains.

Top module: `sbuf_hw_arb`

## Requirements
- R1: After reset the occupancy is zero, stall is low and no port request or load grant is raised.
- R2: The queue holds at most DEPTH (default 8) entries. When it is full, stall is high and an entry presented in that cycle is discarded: it never appears on the port and does not change the occupancy.
- R3: All entry kinds take a slot and count toward the limit. The kind codes are 0 for store, 1 for fence, 2 for atomic and 3 for flush.
- R4: With fewer than HIGH_MARK (default 5) entries queued, a pending load miss is granted when the port is ready and the head waits. The port then carries ld_addr with port_from_store low.
- R5: With HIGH_MARK or more entries queued and a non-fence entry at the head, the head is granted when the port is ready, even if a load miss is pending.
- R6: With entries below HIGH_MARK and no load pending, a non-fence head is granted when the port is ready.
- R7: Entries leave in the order they were accepted, at most one per cycle. A granted entry puts its own kind, address, data and mask on the port with port_from_store high.
- R8: A fence at the head is removed in that cycle with no port request, whether or not the port is ready. A pending load may use the port in that same cycle.
- R9: An entry accepted at a clock edge can be granted in the next cycle. There are no extra pipeline cycles.
- R10: While port_ready is low, neither a load nor a queued entry is granted, and queued stores are kept.
- R11: The occupancy output equals the accepted entries minus the removed ones. A push and a pop in the same cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | An entry is offered this cycle |
| enq_kind | input | 2 | Entry kind: 0 store, 1 fence, 2 atomic, 3 flush |
| enq_addr | input | ADDR_W | Entry address |
| enq_data | input | DATA_W | Entry data |
| enq_mask | input | DATA_W/8 | Entry byte enables |
| stall | output | 1 | Queue full; offered entries are refused |
| occupancy | output | CNT_W | Number of queued entries |
| ld_req | input | 1 | A first-level load miss wants the port |
| ld_addr | input | ADDR_W | Address of the load miss |
| ld_grant | output | 1 | The load miss owns the port this cycle |
| port_ready | input | 1 | The second-level port accepts a request this cycle |
| port_valid | output | 1 | A request is on the port |
| port_from_store | output | 1 | The request comes from the queue head |
| port_kind | output | 2 | Kind of the granted queue entry |
| port_addr | output | ADDR_W | Request address |
| port_data | output | DATA_W | Request data (queue entries) |
| port_mask | output | DATA_W/8 | Request byte enables (queue entries) |

## Verification
The hardest state to reach is the hand-over of priority. The queue has to sit at or above the mark while a load is continuously pending, with fences mixed among the stores. The stimulus holds the port not ready so that the queue can be filled to capacity with a mixed series of kinds, with a store at the head so that nothing retires early. It then releases the port with the load held high. The bench then sees stores win while the count is five or more, a fence retire in the same cycle the load is granted, and the load take over once the count drops to four. A push and a pop in the same cycle at exactly the mark are driven separately.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

   typedef enum logic [1:0] {
      SB_STORE  = 2'd0,
      SB_FENCE  = 2'd1,
      SB_ATOMIC = 2'd2,
      SB_FLUSH  = 2'd3
   } sb_kind_e;

   function automatic logic kind_uses_port(input sb_kind_e k);
      return k != SB_FENCE;
   endfunction

endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring #(
   parameter int DEPTH   = 8,
   parameter int ENTRY_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic               pop,
   input  logic [ENTRY_W-1:0] wr_entry,
   output logic [ENTRY_W-1:0] head_entry,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic               full,
   output logic               empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [PTR_W-1:0]   wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
   logic [ENTRY_W-1:0] slot_q [DEPTH];

   generate
      if (POW2) begin : g_wrap_pow2
         always_comb begin
            wr_ptr_nx = wr_ptr + PTR_W'(1);
            rd_ptr_nx = rd_ptr + PTR_W'(1);
         end
      end else begin : g_wrap_cmp
         always_comb begin
            wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
         end
      end
   endgenerate

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(s))
               slot_q[s] <= wr_entry;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr_nx;
         if (pop)  rd_ptr <= rd_ptr_nx;
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign head_entry = slot_q[rd_ptr];
   assign full       = (count == CNT_W'(DEPTH));
   assign empty      = (count == '0);

   a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   a_r11_count_track: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> count == CNT_W'($past(count) + CNT_W'($past(push)) - CNT_W'($past(pop))));
   a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

endmodule

// File: rtl/sbuf_arb.sv
module sbuf_arb
   import sbuf_pkg::*;
#(
   parameter int CNT_W     = 4,
   parameter int HIGH_MARK = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  sb_kind_e         head_kind,
   input  logic             port_ready,
   input  logic             ld_req,
   output logic             st_grant,
   output logic             ld_grant,
   output logic             fence_retire
);
   logic have_head, st_want, urgent;

   always_comb begin
      have_head    = (count != '0);
      urgent       = (count >= CNT_W'(HIGH_MARK));
      st_want      = have_head && kind_uses_port(head_kind);
      fence_retire = have_head && !kind_uses_port(head_kind);
      st_grant     = port_ready && st_want && (urgent || !ld_req);
      ld_grant     = port_ready && ld_req && !st_grant;
   end

   a_r7_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_grant, ld_grant}));
   a_r8_fence_silent: assert property (@(posedge clk) disable iff (!rst_n)
      fence_retire |-> !st_grant);
   a_r10_port_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !port_ready |-> !(st_grant || ld_grant));
   a_r5_load_yields: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_grant && have_head) |-> (!urgent || head_kind == SB_FENCE));

endmodule

// File: rtl/sbuf_hw_arb.sv
module sbuf_hw_arb
   import sbuf_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int DEPTH     = 8,
   parameter int HIGH_MARK = 5,
   localparam int MASK_W   = DATA_W / 8,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [1:0]        enq_kind,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic [DATA_W-1:0] enq_data,
   input  logic [MASK_W-1:0] enq_mask,
   output logic              stall,
   output logic [CNT_W-1:0]  occupancy,
   input  logic              ld_req,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_grant,
   input  logic              port_ready,
   output logic              port_valid,
   output logic              port_from_store,
   output logic [1:0]        port_kind,
   output logic [ADDR_W-1:0] port_addr,
   output logic [DATA_W-1:0] port_data,
   output logic [MASK_W-1:0] port_mask
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sbuf_hw_arb: DEPTH must be at least 2");
      end
      if (HIGH_MARK < 1 || HIGH_MARK > DEPTH) begin : g_bad_mark
         $error("sbuf_hw_arb: HIGH_MARK must lie in 1..DEPTH");
      end
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("sbuf_hw_arb: DATA_W must be a whole number of bytes");
      end
   endgenerate

   typedef struct packed {
      sb_kind_e          kind;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
      logic [MASK_W-1:0] mask;
   } entry_t;

   localparam int ENTRY_W = $bits(entry_t);

   entry_t           wr_ent, head_ent;
   logic             push, pop, full, empty;
   logic             st_grant, fence_retire;
   logic [CNT_W-1:0] count;

   always_comb begin
      wr_ent.kind = sb_kind_e'(enq_kind);
      wr_ent.addr = enq_addr;
      wr_ent.data = enq_data;
      wr_ent.mask = enq_mask;
   end

   assign push = enq_valid && !full;
   assign pop  = st_grant || fence_retire;

   sbuf_ring #(
      .DEPTH   (DEPTH),
      .ENTRY_W (ENTRY_W)
   ) i_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .pop        (pop),
      .wr_entry   (wr_ent),
      .head_entry (head_ent),
      .count      (count),
      .full       (full),
      .empty      (empty)
   );

   sbuf_arb #(
      .CNT_W     (CNT_W),
      .HIGH_MARK (HIGH_MARK)
   ) i_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .count        (count),
      .head_kind    (head_ent.kind),
      .port_ready   (port_ready),
      .ld_req       (ld_req),
      .st_grant     (st_grant),
      .ld_grant     (ld_grant),
      .fence_retire (fence_retire)
   );

   always_comb begin
      stall           = full;
      occupancy       = count;
      port_valid      = st_grant || ld_grant;
      port_from_store = st_grant;
      port_kind       = st_grant ? head_ent.kind : SB_STORE;
      port_addr       = st_grant ? head_ent.addr : ld_addr;
      port_data       = st_grant ? head_ent.data : '0;
      port_mask       = st_grant ? head_ent.mask : '0;
   end

   a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !pop) |=> stall);
   a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !port_from_store);
   a_r9_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && push) |=> !empty);

endmodule

// File: tb/test_sbuf_hw_arb.sv
module test_sbuf_hw_arb;
   import sbuf_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int MARK  = 5;
   localparam logic [31:0] LD_A = 32'h0000_1D00;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        enq_valid;
   logic [1:0]  enq_kind;
   logic [31:0] enq_addr;
   logic [63:0] enq_data;
   logic [7:0]  enq_mask;
   logic        stall;
   logic [3:0]  occupancy;
   logic        ld_req;
   logic [31:0] ld_addr;
   logic        ld_grant;
   logic        port_ready;
   logic        port_valid, port_from_store;
   logic [1:0]  port_kind;
   logic [31:0] port_addr;
   logic [63:0] port_data;
   logic [7:0]  port_mask;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   logic [1:0]  m_kind [DEPTH];
   logic [31:0] m_addr [DEPTH];
   int m_head = 0, m_tail = 0, m_cnt = 0;

   sbuf_hw_arb i_sbuf_hw_arb (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_addr(enq_addr),
      .enq_data(enq_data), .enq_mask(enq_mask),
      .stall(stall), .occupancy(occupancy),
      .ld_req(ld_req), .ld_addr(ld_addr), .ld_grant(ld_grant),
      .port_ready(port_ready), .port_valid(port_valid),
      .port_from_store(port_from_store), .port_kind(port_kind),
      .port_addr(port_addr), .port_data(port_data), .port_mask(port_mask)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         bad++; total++;
         $display("FAIL watchdog act=%0d exp<=5000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [63:0] data_of(input logic [31:0] a);
      return {a, ~a};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // One cycle: drive, check outputs against the model, advance the model.
   task automatic step(input bit ev, input logic [1:0] kind, input logic [31:0] addr,
                       input bit ldr, input bit pr);
      bit    e_full, e_fence, e_st, e_ld;
      string tag;
      @(negedge clk);
      enq_valid = ev; enq_kind = kind; enq_addr = addr;
      enq_data = data_of(addr); enq_mask = addr[7:0];
      ld_req = ldr; ld_addr = LD_A; port_ready = pr;
      #1;
      e_full  = (m_cnt == DEPTH);
      e_fence = (m_cnt > 0) && (m_kind[m_head] == SB_FENCE);
      e_st    = pr && (m_cnt > 0) && !e_fence && (m_cnt >= MARK || !ldr);
      e_ld    = pr && ldr && !e_st;
      if (e_fence)        tag = "R8";
      else if (!pr)       tag = "R10";
      else if (m_cnt == 0) tag = "R9";
      else if (m_cnt >= MARK) tag = "R5";
      else if (ldr)       tag = "R4";
      else                tag = "R6";
      chk(occupancy == 4'(m_cnt), "R11 occupancy", 64'(occupancy), 64'(m_cnt));
      chk(stall == e_full, "R2 stall", 64'(stall), 64'(e_full));
      chk(port_from_store == e_st, {tag, " store grant"}, 64'(port_from_store), 64'(e_st));
      chk(ld_grant == e_ld, {tag, " load grant"}, 64'(ld_grant), 64'(e_ld));
      chk(port_valid == (e_st || e_ld), {tag, " port valid"}, 64'(port_valid), 64'(e_st || e_ld));
      if (e_st) begin
         chk(port_addr == m_addr[m_head], "R7 addr order", 64'(port_addr), 64'(m_addr[m_head]));
         chk(port_kind == m_kind[m_head], "R7 kind", 64'(port_kind), 64'(m_kind[m_head]));
         chk(port_data == data_of(m_addr[m_head]), "R7 data", port_data, data_of(m_addr[m_head]));
         chk(port_mask == m_addr[m_head][7:0], "R7 mask", 64'(port_mask), 64'(m_addr[m_head][7:0]));
      end
      if (e_ld)
         chk(port_addr == LD_A, "R4 load addr", 64'(port_addr), 64'(LD_A));
      if (e_st || e_fence) begin
         m_head = (m_head + 1) % DEPTH; m_cnt--;
      end
      if (ev && !e_full) begin
         m_kind[m_tail] = kind; m_addr[m_tail] = addr;
         m_tail = (m_tail + 1) % DEPTH; m_cnt++;
      end
   endtask

   task automatic idle(input bit ldr, input bit pr);
      step(1'b0, 2'd0, 32'h0, ldr, pr);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; enq_valid = 0; enq_kind = 0; enq_addr = 0; enq_data = 0;
      enq_mask = 0; ld_req = 0; ld_addr = 0; port_ready = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #1;
      chk(occupancy == 0, "R1 occupancy", 64'(occupancy), 0);
      chk(!stall, "R1 stall", 64'(stall), 0);
      chk(!port_valid && !ld_grant, "R1 no grants", 64'({port_valid, ld_grant}), 0);
   endtask

   task automatic t_latency;
      step(1'b1, SB_STORE, 32'h0000_0040, 1'b0, 1'b1);
      chk(!port_valid, "R9 not same cycle", 64'(port_valid), 0);
      idle(1'b0, 1'b1);
      idle(1'b0, 1'b1);
   endtask

   task automatic t_fill_full;
      logic [1:0] kinds [8] = '{SB_STORE, SB_FENCE, SB_ATOMIC, SB_STORE,
                                SB_FLUSH, SB_FENCE, SB_STORE, SB_STORE};
      for (int i = 0; i < 8; i++)
         step(1'b1, kinds[i], 32'h0000_0100 + 32'(4*i), 1'b0, 1'b0);
      step(1'b1, SB_STORE, 32'h0000_DEAD, 1'b0, 1'b0);
      #1;
      chk(occupancy == 4'd8, "R3 all kinds counted", 64'(occupancy), 8);
      chk(stall, "R2 full stall", 64'(stall), 1);
      for (int i = 0; i < 7; i++) idle(1'b1, 1'b1);
      for (int i = 0; i < 5; i++) idle(1'b0, 1'b1);
      chk(m_cnt == 0, "R2 rejected entry absent", 64'(m_cnt), 0);
   endtask

   task automatic t_push_pop_mark;
      for (int i = 0; i < 5; i++)
         step(1'b1, SB_STORE, 32'h0000_0200 + 32'(4*i), 1'b0, 1'b0);
      step(1'b1, SB_ATOMIC, 32'h0000_0280, 1'b1, 1'b1);
      #1;
      chk(occupancy == 4'd5, "R11 push with pop", 64'(occupancy), 5);
      idle(1'b1, 1'b1);
      for (int i = 0; i < 6; i++) idle(1'b0, 1'b1);
   endtask

   task automatic t_port_busy;
      step(1'b1, SB_STORE, 32'h0000_0300, 1'b1, 1'b0);
      step(1'b1, SB_FLUSH, 32'h0000_0304, 1'b1, 1'b0);
      idle(1'b1, 1'b0);
      idle(1'b0, 1'b0);
      #1;
      chk(occupancy == 4'd2, "R10 stores kept", 64'(occupancy), 2);
      for (int i = 0; i < 3; i++) idle(1'b0, 1'b1);
   endtask

   task automatic t_fence_alone;
      step(1'b1, SB_FENCE, 32'h0000_0400, 1'b0, 1'b0);
      idle(1'b1, 1'b1);
      idle(1'b0, 1'b0);
      #1;
      chk(occupancy == 0, "R8 fence gone", 64'(occupancy), 0);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_fill_full();
      t_push_pop_mark();
      t_port_busy();
      t_fence_alone();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule